// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the two divider settings of a display-lane PLL so that the PLL output lands as close as possible to a requested lane rate. A start strobe captures the reference frequency and the requested rate, both in hertz. The engine then works out the range of legal pre-divider values and visits each candidate in turn. For every candidate it derives the feedback divider and the frequency that setting would really produce. It keeps the setting with the smallest error.

All arithmetic runs through one shared shift-subtract divider, so a search costs a number of divider passes and no wide combinational divide. When the search ends, the block does two things at once: it raises a one-cycle done flag, and it updates the divider outputs, the two packed control words and the achieved rate. A program or sequencer then copies the packed words into the PLL.

The data here is a single request and a single answer, not a stream, so start, busy and done are plain control pins with no valid/ready handshake. A request may be issued in any cycle where busy is low, including the cycle that carries done. A start pulse seen while busy is high is dropped and applies no back-pressure.

Top module: `pll_div_search`

## Requirements
- R1: The target PLL output is twice the requested rate. The reported achieved rate is the chosen setting's output frequency divided by two, rounded down.
- R2: Pre-divider candidates are visited in increasing order, from max(1, ceil(fref / 40 MHz)) up to min(31, floor(fref / 5 MHz)). If this range is empty, there is no candidate.
- R3: For pre-divider p, the feedback divider is floor(target × p / fref), and the output of that setting is floor(fbdiv × fref / p).
- R4: A feedback value below 12, equal to 15, or above 511 disqualifies that candidate.
- R5: A candidate becomes the best only when its absolute error against the target is strictly smaller than the error of the current best. On a tie, the lower pre-divider wins.
- R6: When no candidate qualifies, the prediv and fbdiv outputs keep their previous values and the achieved rate reads 0.
- R7: The pre control word carries prediv in bits 4:0 and fbdiv bit 8 in bit 5, with bits 7:6 zero. The feedback control word carries fbdiv bits 7:0.
- R8: Busy rises on the clock edge that accepts start while idle, and stays high until the result. Done is a single-cycle pulse during which busy is low. The result outputs change only in the cycle done is high.
- R9: Start is ignored while busy. The reference and rate inputs are sampled only on the accepting edge, so changing them during a search has no effect on its result.
- R10: After reset, busy, done, prediv, fbdiv, both control words and the achieved rate are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| fref_hz | input | 32 | Reference frequency in Hz |
| rate_hz | input | 32 | Requested lane rate in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| prediv | output | 5 | Chosen pre-divider |
| fbdiv | output | 9 | Chosen feedback divider |
| ctrl_pre | output | 8 | Packed pre-divider / feedback-high word |
| ctrl_fb | output | 8 | Packed feedback-low word |
| achieved_hz | output | 32 | Achieved lane rate in Hz, 0 if no fit |

## Verification
The bench targets several corner cases:
- A tie between two pre-dividers. A design using a non-strict compare would report the later one.
- A feedback value of exactly 15 as the only candidate. A design that forgot the hole would report 120 MHz-class output instead of falling back.
- Feedback values above 511, a zero reference, and a reference so high that the lower bound exceeds 31. Each of these must give the fallback with the old dividers kept.
- A feedback divider of 400, which checks that bit 8 moves into the pre control word.
- A second start pulse with new inputs in the middle of a search. A design that restarted, or that sampled its inputs late, would return the second request's answer.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {PH_LO, PH_HI, PH_FB, PH_ACT} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} state_e;
endpackage

// File: rtl/pds_divider.sv
// Restoring shift-subtract divider: one quotient bit per clock, W clocks per result.
module pds_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W:0]    rem_sh;
  logic [CW-1:0] cnt;
  logic          run;
  logic          fits;

  always_comb begin
    rem_sh = {rem[W-1:0], quo[W-1]};
    fits   = (rem_sh >= {1'b0, den});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quo <= num;
        rem <= '0;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? (rem_sh - {1'b0, den}) : rem_sh;
        quo <= {quo[W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pds_ctrl.sv
// Sequencer: bounds the pre-divider range, then scores each candidate.
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int          FREQ_W    = 32,
  parameter int          PRE_W     = 5,
  parameter int          FB_W      = 9,
  parameter int          ARITH_W   = 64,
  parameter longint      IF_MAX_HZ = 40_000_000,
  parameter longint      IF_MIN_HZ = 5_000_000,
  parameter int          FB_MIN    = 12,
  parameter int          FB_MAX    = 511,
  parameter int          FB_HOLE   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FREQ_W-1:0]  fref,
  input  logic [FREQ_W-1:0]  rate,
  output logic               div_go,
  output logic [ARITH_W-1:0] div_num,
  output logic [ARITH_W-1:0] div_den,
  input  logic               div_done,
  input  logic [ARITH_W-1:0] div_quo,
  output logic               busy,
  output logic               done,
  output logic [PRE_W-1:0]   prediv,
  output logic [FB_W-1:0]    fbdiv,
  output logic [FREQ_W-1:0]  achieved
);
  localparam int PRE_MAX = (1 << PRE_W) - 1;

  state_e             st;
  phase_e             ph;
  logic [ARITH_W-1:0] f_r, tgt_r, best_d, best_out;
  logic [PRE_W:0]     lo_r;
  logic [PRE_W-1:0]   p_r, p_hi, best_p;
  logic [FB_W-1:0]    fb_r, best_fb;
  logic               found;

  // Combinational views of the divider result
  logic [PRE_W:0]     lo_sat;
  logic [PRE_W-1:0]   hi_sat;
  logic [PRE_W:0]     p_first;
  logic [PRE_W-1:0]   p_nx;
  logic               fb_ok, at_last, better;
  logic [ARITH_W-1:0] err;

  always_comb begin
    lo_sat  = (div_quo > ARITH_W'(PRE_MAX)) ? (PRE_W+1)'(PRE_MAX + 1) : div_quo[PRE_W:0];
    hi_sat  = (div_quo > ARITH_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : div_quo[PRE_W-1:0];
    p_first = (lo_r == '0) ? (PRE_W+1)'(1) : lo_r;
    fb_ok   = (div_quo >= ARITH_W'(FB_MIN)) && (div_quo <= ARITH_W'(FB_MAX)) &&
              (div_quo != ARITH_W'(FB_HOLE));
    err     = (tgt_r >= div_quo) ? (tgt_r - div_quo) : (div_quo - tgt_r);
    better  = (err < best_d);
    at_last = (p_r == p_hi);
    p_nx    = p_r + 1'b1;
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_LO;
      f_r      <= '0;
      tgt_r    <= '0;
      best_d   <= '0;
      best_out <= '0;
      lo_r     <= '0;
      p_r      <= '0;
      p_hi     <= '0;
      best_p   <= '0;
      best_fb  <= '0;
      fb_r     <= '0;
      found    <= 1'b0;
      div_go   <= 1'b0;
      div_num  <= '0;
      div_den  <= '0;
      done     <= 1'b0;
      prediv   <= '0;
      fbdiv    <= '0;
      achieved <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          f_r     <= ARITH_W'(fref);
          tgt_r   <= ARITH_W'({rate, 1'b0});
          best_d  <= '1;
          found   <= 1'b0;
          div_num <= ARITH_W'(fref) + ARITH_W'(IF_MAX_HZ - 1);
          div_den <= ARITH_W'(IF_MAX_HZ);
          div_go  <= 1'b1;
          ph      <= PH_LO;
          st      <= ST_WAIT;
        end
        ST_WAIT: if (div_done) begin
          unique case (ph)
            PH_LO: begin
              lo_r    <= lo_sat;
              div_num <= f_r;
              div_den <= ARITH_W'(IF_MIN_HZ);
              div_go  <= 1'b1;
              ph      <= PH_HI;
            end
            PH_HI: begin
              if (f_r == '0 || p_first > {1'b0, hi_sat}) begin
                st <= ST_DONE;
              end else begin
                p_r     <= p_first[PRE_W-1:0];
                p_hi    <= hi_sat;
                div_num <= tgt_r * ARITH_W'(p_first);
                div_den <= f_r;
                div_go  <= 1'b1;
                ph      <= PH_FB;
              end
            end
            PH_FB: begin
              if (fb_ok) begin
                fb_r    <= div_quo[FB_W-1:0];
                div_num <= div_quo * f_r;
                div_den <= ARITH_W'(p_r);
                div_go  <= 1'b1;
                ph      <= PH_ACT;
              end else if (at_last) begin
                st <= ST_DONE;
              end else begin
                p_r     <= p_nx;
                div_num <= tgt_r * ARITH_W'(p_nx);
                div_den <= f_r;
                div_go  <= 1'b1;
                ph      <= PH_FB;
              end
            end
            PH_ACT: begin
              if (better) begin
                best_d   <= err;
                best_out <= div_quo;
                best_p   <= p_r;
                best_fb  <= fb_r;
                found    <= 1'b1;
              end
              if (at_last) begin
                st <= ST_DONE;
              end else begin
                p_r     <= p_nx;
                div_num <= tgt_r * ARITH_W'(p_nx);
                div_den <= f_r;
                div_go  <= 1'b1;
                ph      <= PH_FB;
              end
            end
            default: st <= ST_DONE;
          endcase
        end
        ST_DONE: begin
          if (found) begin
            prediv   <= best_p;
            fbdiv    <= best_fb;
            achieved <= best_out[FREQ_W:1];
          end else begin
            achieved <= '0;
          end
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pds_fields.sv
// Packs the divider settings into the two PLL control words.
module pds_fields #(
  parameter int PRE_W = 5,
  parameter int FB_W  = 9
) (
  input  logic [PRE_W-1:0] prediv,
  input  logic [FB_W-1:0]  fbdiv,
  output logic [7:0]       ctrl_pre,
  output logic [7:0]       ctrl_fb
);
  always_comb begin
    ctrl_pre               = '0;
    ctrl_pre[PRE_W-1:0]    = prediv;
    ctrl_pre[PRE_W]        = fbdiv[FB_W-1];
    ctrl_fb                = fbdiv[7:0];
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int     FREQ_W    = 32,
  parameter int     PRE_W     = 5,
  parameter int     FB_W      = 9,
  parameter int     ARITH_W   = 64,
  parameter longint IF_MAX_HZ = 40_000_000,
  parameter longint IF_MIN_HZ = 5_000_000,
  parameter int     FB_MIN    = 12,
  parameter int     FB_MAX    = 511,
  parameter int     FB_HOLE   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] fref_hz,
  input  logic [FREQ_W-1:0] rate_hz,
  output logic              busy,
  output logic              done,
  output logic [PRE_W-1:0]  prediv,
  output logic [FB_W-1:0]   fbdiv,
  output logic [7:0]        ctrl_pre,
  output logic [7:0]        ctrl_fb,
  output logic [FREQ_W-1:0] achieved_hz
);
  logic               div_go, div_done;
  logic [ARITH_W-1:0] div_num, div_den, div_quo;

  pds_ctrl #(
    .FREQ_W(FREQ_W), .PRE_W(PRE_W), .FB_W(FB_W), .ARITH_W(ARITH_W),
    .IF_MAX_HZ(IF_MAX_HZ), .IF_MIN_HZ(IF_MIN_HZ),
    .FB_MIN(FB_MIN), .FB_MAX(FB_MAX), .FB_HOLE(FB_HOLE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .fref(fref_hz), .rate(rate_hz),
    .div_go(div_go), .div_num(div_num), .div_den(div_den),
    .div_done(div_done), .div_quo(div_quo),
    .busy(busy), .done(done), .prediv(prediv), .fbdiv(fbdiv), .achieved(achieved_hz)
  );

  pds_divider #(.W(ARITH_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_quo)
  );

  pds_fields #(.PRE_W(PRE_W), .FB_W(FB_W)) u_fields (
    .prediv(prediv), .fbdiv(fbdiv), .ctrl_pre(ctrl_pre), .ctrl_fb(ctrl_fb)
  );
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [4:0] prediv,
  input logic [8:0] fbdiv,
  input logic [31:0] achieved_hz
);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(prediv) && $stable(fbdiv) && $stable(achieved_hz)));
  // R9
  busy_persist_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));
  // R6
  fallback_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && achieved_hz == '0) |-> ($stable(prediv) && $stable(fbdiv)));
  // R4
  fb_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && achieved_hz != '0) |-> (fbdiv >= 9'd12 && fbdiv != 9'd15));
  // R2
  prediv_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && achieved_hz != '0) |-> (prediv != '0));
endmodule

bind pll_div_search pll_div_search_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .prediv(prediv), .fbdiv(fbdiv), .achieved_hz(achieved_hz)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] fref_hz = '0;
  logic [31:0] rate_hz = '0;
  logic        busy, done;
  logic [4:0]  prediv;
  logic [8:0]  fbdiv;
  logic [7:0]  ctrl_pre, ctrl_fb;
  logic [31:0] achieved_hz;

  pll_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fref_hz(fref_hz), .rate_hz(rate_hz),
    .busy(busy), .done(done), .prediv(prediv), .fbdiv(fbdiv),
    .ctrl_pre(ctrl_pre), .ctrl_fb(ctrl_fb), .achieved_hz(achieved_hz)
  );

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;
  longint unsigned exp_p = 0, exp_fb = 0, exp_ach = 0;
  longint unsigned pend_p = 0, pend_fb = 0, pend_ach = 0;
  bit m_busy = 1'b0, prev_start = 1'b0;
  logic [31:0] prev_f = '0, prev_r = '0;

  // Behavioural reference of the search (R1..R6)
  task automatic ref_search(input longint unsigned f, input longint unsigned r,
                            inout longint unsigned p_o, inout longint unsigned fb_o,
                            output longint unsigned ach_o);
    longint unsigned tgt, lo, hi, best_d, bp, bfb, bout;
    bit any;
    tgt = 2 * r; any = 0; best_d = 64'hFFFF_FFFF_FFFF_FFFF; bp = 0; bfb = 0; bout = 0;
    lo = (f + 40_000_000 - 1) / 40_000_000;
    hi = f / 5_000_000;
    if (hi > 31) hi = 31;
    if (lo < 1) lo = 1;
    for (longint unsigned q = lo; q <= hi; q++) begin
      longint unsigned fbq, act, d;
      fbq = (tgt * q) / f;
      if (fbq < 12 || fbq == 15 || fbq > 511) continue;
      act = (fbq * f) / q;
      d = (act > tgt) ? act - tgt : tgt - act;
      if (d < best_d) begin best_d = d; bp = q; bfb = fbq; bout = act; any = 1; end
    end
    if (any) begin p_o = bp; fb_o = bfb; ach_o = bout / 2; end
    else ach_o = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!finished && cycles >= 150000) begin
      fails++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 0);
      finish_run();
    end
    if (rst_n && !finished) begin
      if (prev_start && !m_busy) begin
        m_busy = 1'b1;
        pend_p = exp_p; pend_fb = exp_fb;
        ref_search(prev_f, prev_r, pend_p, pend_fb, pend_ach);
      end
      if (done) begin
        chk(m_busy, "R8 done without request", 1, 0);
        m_busy = 1'b0;
        exp_p = pend_p; exp_fb = pend_fb; exp_ach = pend_ach;
      end
      chk(busy == m_busy, "R8 R9 busy", busy, m_busy);
      chk(prediv == exp_p, "R2 R3 R5 prediv", prediv, exp_p);
      chk(fbdiv == exp_fb, "R3 R4 R6 fbdiv", fbdiv, exp_fb);
      chk(achieved_hz == exp_ach, "R1 R6 achieved", achieved_hz, exp_ach);
      chk(ctrl_pre == 8'((((exp_fb >> 8) & 1) << 5) | exp_p), "R7 ctrl_pre", ctrl_pre,
          (((exp_fb >> 8) & 1) << 5) | exp_p);
      chk(ctrl_fb == 8'(exp_fb & 255), "R7 ctrl_fb", ctrl_fb, exp_fb & 255);
      prev_start = start; prev_f = fref_hz; prev_r = rate_hz;
    end
  end

  task automatic pulse(input logic [31:0] f, input logic [31:0] r);
    @(posedge clk); #2;
    fref_hz = f; rate_hz = r; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic run(input logic [31:0] f, input logic [31:0] r);
    pulse(f, r);
    @(negedge clk);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0, "R10 reset busy/done", {busy, done}, 0);
    chk(prediv == 0 && fbdiv == 0, "R10 reset dividers", {prediv, fbdiv}, 0);
    chk(ctrl_pre == 0 && ctrl_fb == 0 && achieved_hz == 0, "R10 reset words",
        {ctrl_pre, ctrl_fb}, 0);
    @(posedge clk); #2; rst_n = 1'b1;

    run(32'd24_000_000, 32'd500_000_000);    // R3 exact fit at a middle pre-divider
    run(32'd10_000_000, 32'd2_000_000_000);  // R7 feedback bit 8 set
    run(32'd3_000_000, 32'd500_000_000);     // R2 R6 empty range keeps old dividers
    run(32'd24_000_000, 32'd50_000_000);     // R4 R5 low values skipped, tie keeps earlier
    run(32'd8_000_000, 32'd60_000_000);      // R4 R6 only candidate is the hole value
    run(32'd5_000_000, 32'd2_000_000_000);   // R4 R6 feedback above the maximum
    run(32'd400_000_000, 32'd1_000_000_000); // R2 upper bound clamped to 31
    run(32'd0, 32'd100_000_000);             // R6 zero reference
    run(32'd2_000_000_000, 32'd500_000_000); // R2 lower bound above 31
    run(32'd27_000_000, 32'd333_000_000);    // R1 R5 inexact rate
    // R9 second start mid-search with new inputs is ignored
    pulse(32'd24_000_000, 32'd1_000_000_000);
    repeat (20) @(posedge clk);
    pulse(32'd12_000_000, 32'd400_000_000);
    fref_hz = 32'd19_200_000; rate_hz = 32'd750_000_000;
    @(negedge clk);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    run(32'd19_200_000, 32'd750_000_000);    // R1 R3 after the ignored pulse
    finish_run();
  end
endmodule